// File: doc/BRIEF.md
# Polled Console I/O Register Window

This block is a slave on a simple processor load/store bus. It is a single-cycle strobe interface: select, write enable, address and write data in, read data out combinationally in the same cycle. It places two byte channels in a small register window at the top of the address space. One channel carries input from a keyboard-like source and the other carries output to a display-like sink. Software polls a ready flag in a channel's control register. When the flag is set it loads or stores the channel's data register. That access clears the flag by itself.

Each flag is read from the processor's side. On the input channel it means a byte is waiting to be loaded. On the output channel it means a byte may be stored. On the device side, an input byte arrives with a one-cycle valid strobe. An output byte leaves under a valid/accept handshake. Each channel has an interrupt enable bit. The block raises one level interrupt request while any enabled channel is ready, so software can stop polling when it wants to.

The window starts at 0xFFFF0000 and spans 64 KiB. The registers are, by byte offset: input control 0x0, input data 0x4, output control 0x8, output data 0xC. Control bits are: bit 0 ready (read only), bit 1 interrupt enable (read/write), and bit 2 overrun (input control only, read only, sticky).

Top module: `mmio_poll_port`

## Requirements
- R1: After reset, input control reads 0, output control reads 1 (ready, enable clear), outValid is 0 and irq is 0.
- R2: An inValid pulse captures inByte and sets input ready; input control bit 0 reads 1 from the next cycle.
- R3: A load of input data while ready returns the byte in bits 7:0 with zeros above, and input ready reads 0 afterwards.
- R4: A load of input data while input ready is 0 returns the last captured byte and changes no state.
- R5: A store to output data while output ready is 1 presents bits 7:0 of the write data on outByte with outValid 1 from the next cycle, and output control bit 0 reads 0.
- R6: A cycle with outValid and outAccept both 1 drops outValid and sets output ready back to 1 in the next cycle.
- R7: A store to output data while output ready is 0 is ignored; outByte keeps the pending byte.
- R8: Bit 1 of each control register is a writable, readable interrupt enable; irq is 1 exactly while some channel has both its enable and its ready set.
- R9: A new input byte arriving while input ready is 1 replaces the held byte and sets the sticky overrun bit 2 of input control; a load of input control returns the bit and clears it.
- R10: Software writes to bits 0 and 2 are ignored. Unmapped offsets inside the window read 0. Accesses outside the window read 0 and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access strobe for this cycle |
| busWe | input | 1 | 1 = store, 0 = load |
| busAddr | input | 32 | Byte address |
| busWdata | input | 32 | Store data |
| busRdata | output | 32 | Load data, valid in the access cycle |
| inValid | input | 1 | Device input byte strobe |
| inByte | input | 8 | Device input byte |
| outValid | output | 1 | Output byte pending for the device |
| outByte | output | 8 | Output byte |
| outAccept | input | 1 | Device takes the pending output byte |
| irq | output | 1 | Level interrupt request |

## Verification
A stuck or lost ready flag shows on the next control-register load. A flag that fails to clear after a data access shows on the first poll that follows. An output flag that never returns shows on the first poll after an accept cycle. A wrong overrun state shows on the next input-control load: the read-and-clear gives back 5 and then 1. A bad interrupt enable or a bad ready term shows on irq in the same cycle as the register change. A decode fault either writes a register it should not touch, which shows on outValid or on a later read, or returns non-zero data in the access cycle itself.

// File: rtl/mmio_poll_pkg.sv
package mmio_poll_pkg;
  localparam int RDY_BIT = 0;
  localparam int IE_BIT  = 1;
  localparam int OVR_BIT = 2;

  typedef struct packed {
    logic rdInCtrl;
    logic rdInData;
    logic wrInCtrl;
    logic wrOutCtrl;
    logic wrOutData;
  } ioStrobe_t;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_IN_CTRL,
    SEL_IN_DATA,
    SEL_OUT_CTRL,
    SEL_OUT_DATA
  } rdSel_t;
endpackage

// File: rtl/mmio_poll_ctrl.sv
module mmio_poll_ctrl
  import mmio_poll_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int WIN_BITS = 16,
  parameter logic [ADDR_W-1:0] BASE = 32'hFFFF0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output ioStrobe_t         stb,
  output rdSel_t            rdSel
);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam logic [WIN_BITS-1:0] OFF_IN_CTRL  = WIN_BITS'(0 * WORD_BYTES);
  localparam logic [WIN_BITS-1:0] OFF_IN_DATA  = WIN_BITS'(1 * WORD_BYTES);
  localparam logic [WIN_BITS-1:0] OFF_OUT_CTRL = WIN_BITS'(2 * WORD_BYTES);
  localparam logic [WIN_BITS-1:0] OFF_OUT_DATA = WIN_BITS'(3 * WORD_BYTES);

  logic                inWindow;
  logic [WIN_BITS-1:0] offset;
  logic                hit;

  assign inWindow = busAddr[ADDR_W-1:WIN_BITS] == BASE[ADDR_W-1:WIN_BITS];
  assign offset   = busAddr[WIN_BITS-1:0];
  assign hit      = busSel && inWindow;

  always_comb begin
    stb   = '0;
    rdSel = SEL_NONE;
    if (hit) begin
      unique case (offset)
        OFF_IN_CTRL: begin
          rdSel = busWe ? SEL_NONE : SEL_IN_CTRL;
          stb.rdInCtrl = !busWe;
          stb.wrInCtrl = busWe;
        end
        OFF_IN_DATA: begin
          rdSel = busWe ? SEL_NONE : SEL_IN_DATA;
          stb.rdInData = !busWe;
        end
        OFF_OUT_CTRL: begin
          rdSel = busWe ? SEL_NONE : SEL_OUT_CTRL;
          stb.wrOutCtrl = busWe;
        end
        OFF_OUT_DATA: begin
          rdSel = busWe ? SEL_NONE : SEL_OUT_DATA;
          stb.wrOutData = busWe;
        end
        default: ;
      endcase
    end
  end

  // R10: at most one register action per bus cycle
  p_strobe_onehot_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb));
  // R10: nothing decodes when the bus is idle
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busSel |-> (stb == '0 && rdSel == SEL_NONE));
endmodule

// File: rtl/mmio_poll_dp.sv
module mmio_poll_dp
  import mmio_poll_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ioStrobe_t         stb,
  input  rdSel_t            rdSel,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              inValid,
  input  logic [BYTE_W-1:0] inByte,
  output logic              outValid,
  output logic [BYTE_W-1:0] outByte,
  input  logic              outAccept,
  output logic              irq
);
  logic [BYTE_W-1:0] inReg, outReg;
  logic inReady, inOvr, inIe;
  logic outFull, outIe;
  logic outReady;

  assign outReady = !outFull;

  // input channel
  always_ff @(posedge clk) begin
    if (!rstN) begin
      inReg   <= '0;
      inReady <= 1'b0;
      inOvr   <= 1'b0;
      inIe    <= 1'b0;
    end else begin
      if (inValid) begin
        inReg   <= inByte;
        inReady <= 1'b1;
      end else if (stb.rdInData) begin
        inReady <= 1'b0;
      end
      if (inValid && inReady && !stb.rdInData)
        inOvr <= 1'b1;
      else if (stb.rdInCtrl)
        inOvr <= 1'b0;
      if (stb.wrInCtrl)
        inIe <= busWdata[IE_BIT];
    end
  end

  // output channel
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outReg  <= '0;
      outFull <= 1'b0;
      outIe   <= 1'b0;
    end else begin
      if (stb.wrOutData && outReady) begin
        outReg  <= busWdata[BYTE_W-1:0];
        outFull <= 1'b1;
      end else if (outFull && outAccept) begin
        outFull <= 1'b0;
      end
      if (stb.wrOutCtrl)
        outIe <= busWdata[IE_BIT];
    end
  end

  always_comb begin
    busRdata = '0;
    unique case (rdSel)
      SEL_IN_CTRL: begin
        busRdata[RDY_BIT] = inReady;
        busRdata[IE_BIT]  = inIe;
        busRdata[OVR_BIT] = inOvr;
      end
      SEL_IN_DATA:  busRdata[BYTE_W-1:0] = inReg;
      SEL_OUT_CTRL: begin
        busRdata[RDY_BIT] = outReady;
        busRdata[IE_BIT]  = outIe;
      end
      SEL_OUT_DATA: busRdata[BYTE_W-1:0] = outReg;
      default: ;
    endcase
  end

  assign outValid = outFull;
  assign outByte  = outReg;
  assign irq      = (inIe && inReady) || (outIe && outReady);

  p_ready_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> inReady);
  p_read_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdInData && !inValid) |=> !inReady);
  p_idle_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdInData && !inReady && !inValid) |=> ($stable(inReg) && !inReady));
  p_store_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrOutData && outFull) |=> $stable(outReg));
  p_accept_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outFull && outAccept) |=> !outFull);
  p_overrun_r9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && !stb.rdInData) |=> inOvr);
endmodule

// File: rtl/mmio_poll_port.sv
module mmio_poll_port
  import mmio_poll_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int BYTE_W   = 8,
  parameter int WIN_BITS = 16,
  parameter logic [ADDR_W-1:0] BASE = 32'hFFFF0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              inValid,
  input  logic [BYTE_W-1:0] inByte,
  output logic              outValid,
  output logic [BYTE_W-1:0] outByte,
  input  logic              outAccept,
  output logic              irq
);
  ioStrobe_t stb;
  rdSel_t    rdSel;

  mmio_poll_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_BITS(WIN_BITS), .BASE(BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .stb(stb), .rdSel(rdSel)
  );

  mmio_poll_dp #(
    .DATA_W(DATA_W), .BYTE_W(BYTE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdSel(rdSel),
    .busWdata(busWdata), .busRdata(busRdata),
    .inValid(inValid), .inByte(inByte),
    .outValid(outValid), .outByte(outByte), .outAccept(outAccept),
    .irq(irq)
  );
endmodule

// File: tb/mmio_poll_port_tb.sv
module mmio_poll_port_tb;
  localparam logic [31:0] IN_CTRL  = 32'hFFFF0000;
  localparam logic [31:0] IN_DATA  = 32'hFFFF0004;
  localparam logic [31:0] OUT_CTRL = 32'hFFFF0008;
  localparam logic [31:0] OUT_DATA = 32'hFFFF000C;

  localparam int K_RDATA = 0, K_OBYTE = 1, K_OVALID = 2, K_IRQ = 3;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic clk = 0, rstN = 0;
  logic busSel = 0, busWe = 0;
  logic [31:0] busAddr = '0, busWdata = '0;
  logic [31:0] busRdata;
  logic inValid = 0, outAccept = 0;
  logic [7:0] inByte = '0;
  logic outValid, irq;
  logic [7:0] outByte;

  int nCmp = 0, nBad = 0;
  item_t sb[$];
  bit done = 0;

  always #10 clk = ~clk;

  mmio_poll_port u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .inValid(inValid), .inByte(inByte), .outValid(outValid),
    .outByte(outByte), .outAccept(outAccept), .irq(irq)
  );

  // monitor: compares queued expectations mid low phase
  always @(negedge clk) begin
    #8;
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      case (it.kind)
        K_RDATA:  act = busRdata;
        K_OBYTE:  act = {24'b0, outByte};
        K_OVALID: act = {31'b0, outValid};
        default:  act = {31'b0, irq};
      endcase
      nCmp++;
      if (act !== it.exp) begin
        nBad++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic drive(input logic s, input logic w, input logic [31:0] a,
                       input logic [31:0] d, input logic iv, input logic [7:0] ib,
                       input logic acc);
    @(negedge clk); #1;
    busSel = s; busWe = w; busAddr = a; busWdata = d;
    inValid = iv; inByte = ib; outAccept = acc;
  endtask

  task automatic expect_item(input int k, input logic [31:0] e, input string t);
    item_t it;
    it.kind = k; it.exp = e; it.tag = t;
    sb.push_back(it);
  endtask

  task automatic rd(input logic [31:0] a, input logic [31:0] e, input string t);
    drive(1, 0, a, '0, 0, '0, 0);
    expect_item(K_RDATA, e, t);
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    drive(1, 1, a, d, 0, '0, 0);
  endtask

  task automatic pushIn(input logic [7:0] b);
    drive(0, 0, '0, '0, 1, b, 0);
  endtask

  task automatic accept();
    drive(0, 0, '0, '0, 0, '0, 1);
  endtask

  task automatic port(input int k, input logic [31:0] e, input string t);
    drive(0, 0, '0, '0, 0, '0, 0);
    expect_item(k, e, t);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      nCmp++; nBad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    rd(IN_CTRL, 32'h0, "R1 in ctrl");
    rd(OUT_CTRL, 32'h1, "R1 out ctrl");
    port(K_IRQ, 0, "R1 irq");
    port(K_OVALID, 0, "R1 outValid");
    // R2..R4 input path
    pushIn(8'hA5);
    rd(IN_CTRL, 32'h1, "R2 ready set");
    rd(IN_DATA, 32'hA5, "R3 data");
    rd(IN_CTRL, 32'h0, "R3 ready cleared");
    rd(IN_DATA, 32'hA5, "R4 idle read data");
    rd(IN_CTRL, 32'h0, "R4 idle read no change");
    // R5..R7 output path
    wr(OUT_DATA, 32'h123456C3);
    port(K_OVALID, 1, "R5 outValid");
    port(K_OBYTE, 32'hC3, "R5 outByte");
    rd(OUT_CTRL, 32'h0, "R5 out ready cleared");
    wr(OUT_DATA, 32'h77);
    port(K_OBYTE, 32'hC3, "R7 store ignored");
    rd(OUT_DATA, 32'hC3, "R7 out data kept");
    accept();
    port(K_OVALID, 0, "R6 outValid dropped");
    rd(OUT_CTRL, 32'h1, "R6 out ready back");
    wr(OUT_DATA, 32'h3C);
    port(K_OBYTE, 32'h3C, "R5 second byte");
    accept();
    // R8 interrupt enables
    wr(IN_CTRL, 32'h2);
    rd(IN_CTRL, 32'h2, "R8 in enable readback");
    port(K_IRQ, 0, "R8 enabled but idle");
    pushIn(8'h11);
    port(K_IRQ, 1, "R8 input irq");
    rd(IN_DATA, 32'h11, "R8 data");
    port(K_IRQ, 0, "R8 irq cleared by read");
    wr(OUT_CTRL, 32'h2);
    port(K_IRQ, 1, "R8 output irq");
    rd(OUT_CTRL, 32'h3, "R8 out enable readback");
    wr(OUT_CTRL, 32'h0);
    wr(IN_CTRL, 32'h0);
    port(K_IRQ, 0, "R8 all disabled");
    // R9 overrun
    pushIn(8'h22);
    pushIn(8'h33);
    rd(IN_CTRL, 32'h5, "R9 overrun set");
    rd(IN_CTRL, 32'h1, "R9 overrun cleared on read");
    rd(IN_DATA, 32'h33, "R9 newest byte kept");
    // R10 decode and read-only bits
    wr(IN_CTRL, 32'h5);
    rd(IN_CTRL, 32'h0, "R10 ro bits ignored");
    wr(OUT_CTRL, 32'h4);
    rd(OUT_CTRL, 32'h1, "R10 out ro bits ignored");
    rd(32'hFFFF0010, 32'h0, "R10 unmapped offset");
    rd(32'hFFFF0002, 32'h0, "R10 unaligned offset");
    wr(32'h0000000C, 32'h99);
    port(K_OVALID, 0, "R10 outside store ignored");
    pushIn(8'h44);
    rd(32'h00000000, 32'h0, "R10 outside read zero");
    rd(IN_CTRL, 32'h1, "R10 outside read kept ready");
    rd(IN_DATA, 32'h44, "R10 byte intact");
    port(K_IRQ, 0, "R10 final idle");
    drive(0, 0, '0, '0, 0, '0, 0);
    @(negedge clk); #9;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule